// File: doc/BRIEF.md
# Four-Axis Joystick Position Timer

This block turns the pulse width of up to four joystick one-shot inputs into counts that software can read. Each axis input is high while its external timing circuit is charging. After a measurement starts, a counter for every enabled axis runs at a selectable fraction of the clock rate until that axis input drops. The counts stay held until the next measurement, and software reads them one axis at a time through a small register window.

A measurement starts when software writes to the value register. It can also start by itself: in continuous mode the block starts the next measurement as soon as the previous one is done. A ready flag tells software that all enabled axes have finished. If the interrupt enable is set, an interrupt line follows that flag.

Register window (`bus_addr`): 0 = axis control, 1 = axis value, 2 = timing control, 3 = unused and reads zero. Reads are combinational from `bus_addr`. Writes take effect on the clock edge where `bus_wr` is high.

Top module: `joy_axis_timer`

## Requirements
- R1: Bits 3:0 of the axis control register enable axes 0 to 3. A start clears the count of each enabled axis and measures it. The count of a disabled axis keeps its previous value.
- R2: After a start, an enabled axis count increases by one on each prescaler tick while its input is high. The axis finishes on the first cycle its input is sampled low. If an input is high for L cycles after the start edge, the count is floor(L/D).
- R3: Bits 2:1 of the timing control register pick the divisor D: 0 gives 1, 1 gives 2, 2 gives 20, 3 gives 200. The prescaler restarts at every measurement start.
- R4: A count stops at 2^COUNT_W-1, and that axis then finishes even if its input is still high. The value is read zero-extended to 16 bits.
- R5: Bits 5:4 of the axis control register select which axis count is returned when the value register (address 1) is read: 0 gives axis 0, up to 3 for axis 3.
- R6: Bit 7 of the axis control register reads as the ready flag. It goes to 1 once no enabled axis is still measuring. A start clears it. Writes to bit 7 are ignored.
- R7: Any write to address 1 starts a measurement. It also restarts a measurement that is still running.
- R8: When bit 6 of the axis control register is set, a new measurement starts on its own in the cycle after each completion, so the ready flag pulses repeatedly.
- R9: `irq` is high exactly when bit 0 of the timing control register is set and the ready flag is 1.
- R10: After reset every register reads zero and `irq` is low. Bits 7:3 of the timing control register always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| axis_in | input | 4 | One-shot inputs, high while timing |
| irq | output | 1 | Interrupt, ready flag gated by its enable |

## Verification
The bench builds the block with COUNT_W=10 and keeps the default divisors of 2, 20 and 200. With this width, saturation at 1023 takes about a thousand cycles instead of sixty-five thousand. That lets the same vector walk cover saturation, all four divisor codes, partial enable masks with retained counts, and zero-length pulses. A bench one-shot model, fired by the value-register write, supplies pulse lengths. Continuous mode and interrupt gating are then exercised in directed tests.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int NUM_AXES = 4;

  localparam logic [1:0] ADDR_AXCTL = 2'd0;
  localparam logic [1:0] ADDR_VALUE = 2'd1;
  localparam logic [1:0] ADDR_TMCTL = 2'd2;

  // Divisor picked by the 2-bit rate code.
  function automatic int unsigned rate_div(input logic [1:0] code,
                                           input int unsigned d_half,
                                           input int unsigned d_twen,
                                           input int unsigned d_slow);
    case (code)
      2'd0:    return 1;
      2'd1:    return d_half;
      2'd2:    return d_twen;
      default: return d_slow;
    endcase
  endfunction

  // True when a count step reaches the saturation value.
  function automatic logic hits_top(input int unsigned cur, input int unsigned top);
    return (cur + 1) >= top;
  endfunction
endpackage

// File: rtl/joy_prescaler.sv
module joy_prescaler #(
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned DIV_TWEN = 20,
  parameter int unsigned DIV_SLOW = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] rate,
  output logic       tick
);
  import joy_pkg::*;
  localparam int PW = $clog2(DIV_SLOW + 1) + 1;

  logic [PW-1:0] cnt;
  int unsigned   div;

  always_comb begin
    div  = rate_div(rate, DIV_HALF, DIV_TWEN, DIV_SLOW);
    tick = (32'(cnt) + 32'd1) >= div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/joy_axis_ctr.sv
module joy_axis_ctr #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               enable,
  input  logic               tick,
  input  logic               axis_in,
  output logic [COUNT_W-1:0] count,
  output logic               active
);
  import joy_pkg::*;
  localparam int unsigned TOP = (1 << COUNT_W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      active <= 1'b0;
    end else if (start) begin
      active <= enable;
      if (enable) count <= '0;
    end else if (active) begin
      if (!axis_in) begin
        active <= 1'b0;
      end else if (tick) begin
        count <= count + 1'b1;
        if (hits_top(32'(count), TOP)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer #(
  parameter int          COUNT_W  = 16,
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned DIV_TWEN = 20,
  parameter int unsigned DIV_SLOW = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [3:0]  axis_in,
  output logic        irq
);
  import joy_pkg::*;

  logic [NUM_AXES-1:0]               ax_en;
  logic [1:0]                        ax_sel;
  logic                              cont;
  logic                              irq_en;
  logic [1:0]                        rate;
  logic                              running;
  logic                              ready;
  logic                              wr_value;
  logic                              auto_start;
  logic                              start;
  logic                              tick;
  logic [NUM_AXES-1:0]               active;
  logic [NUM_AXES-1:0][COUNT_W-1:0]  counts;
  logic                              unused_wbits;

  assign unused_wbits = ^bus_wdata[7:3];

  // Start events, exposed as named wires for the checker.
  assign wr_value   = bus_wr && (bus_addr == ADDR_VALUE);
  assign auto_start = cont && !running && !wr_value;
  assign start      = wr_value || auto_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_en  <= '0;
      ax_sel <= '0;
      cont   <= 1'b0;
      irq_en <= 1'b0;
      rate   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_AXCTL) begin
        ax_en  <= bus_wdata[3:0];
        ax_sel <= bus_wdata[5:4];
        cont   <= bus_wdata[6];
      end
      if (bus_addr == ADDR_TMCTL) begin
        irq_en <= bus_wdata[0];
        rate   <= bus_wdata[2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ready   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      ready   <= 1'b0;
    end else if (running && (active == '0)) begin
      running <= 1'b0;
      ready   <= 1'b1;
    end
  end

  joy_prescaler #(
    .DIV_HALF(DIV_HALF), .DIV_TWEN(DIV_TWEN), .DIV_SLOW(DIV_SLOW)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(start), .rate(rate), .tick(tick)
  );

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    joy_axis_ctr #(.COUNT_W(COUNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(ax_en[k]),
      .tick(tick), .axis_in(axis_in[k]), .count(counts[k]), .active(active[k])
    );
  end

  always_comb begin
    case (bus_addr)
      ADDR_AXCTL: bus_rdata = {8'h00, ready, cont, ax_sel, ax_en};
      ADDR_VALUE: bus_rdata = 16'(counts[ax_sel]);
      ADDR_TMCTL: bus_rdata = {13'h0000, rate, irq_en};
      default:    bus_rdata = 16'h0000;
    endcase
  end

  assign irq = irq_en && ready;
endmodule

// File: rtl/joy_axis_timer_chk.sv
module joy_axis_timer_chk #(
  parameter int COUNT_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     wr_value,
  input logic                     tick,
  input logic [1:0]               rate,
  input logic                     ready,
  input logic                     cont,
  input logic                     irq,
  input logic                     irq_en,
  input logic [3:0]               ax_en,
  input logic [3:0]               active,
  input logic [3:0][COUNT_W-1:0]  counts
);
  localparam logic [COUNT_W-1:0] TOP = '1;

  assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (active == 4'b0000));

  assert_value_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_value |=> !ready);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && ready));

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != 2'd0 && tick) |=> (!tick || rate == 2'd0));

  assert_cont_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cont) |=> !ready);

  for (genvar k = 0; k < 4; k++) begin : g_ax
    assert_disabled_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ax_en[k]) |=> $stable(counts[k]));

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (counts[k] == TOP && !start) |=> counts[k] == TOP);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active[k] && !start) |=> $stable(counts[k]));
  end
endmodule

bind joy_axis_timer joy_axis_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_value(wr_value), .tick(tick),
  .rate(rate), .ready(ready), .cont(cont), .irq(irq), .irq_en(irq_en),
  .ax_en(ax_en), .active(active), .counts(counts)
);

// File: tb/joy_axis_timer_tb.sv
module joy_axis_timer_tb;
  localparam int CW  = 10;
  localparam int TOP = (1 << CW) - 1;
  localparam int NV  = 6;
  // enables, rate code, pulse lengths of axes 0..3
  localparam int VEC [NV][6] = '{
    '{15, 0,    5,  17,   0,   40},
    '{ 5, 1,    9, 100,  33,    2},
    '{10, 2,   45,   3, 400,   59},
    '{ 3, 3,  650, 199,   0,    0},
    '{ 9, 0, 1500,   0,   0, 3000},
    '{ 6, 1,    0,   1,   2,    3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [15:0] bus_rdata;
  logic [3:0]  axis_in;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int len [4] = '{0, 0, 0, 0};
  int rem [4] = '{0, 0, 0, 0};
  int expv [4] = '{0, 0, 0, 0};
  bit finished = 1'b0;

  always #10 clk = ~clk;

  joy_axis_timer #(.COUNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .axis_in(axis_in), .irq(irq)
  );

  // One-shot model: fired by a write to the value register.
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (bus_wr && bus_addr == 2'd1) rem[k] <= len[k];
      else if (rem[k] != 0)           rem[k] <= rem[k] - 1;
    end
  end

  always_comb
    for (int k = 0; k < 4; k++) axis_in[k] = (rem[k] != 0);

  function automatic int divisor(input int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    if (code == 2) return 20;
    return 200;
  endfunction

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_ready(input string tag);
    int v = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (v[7]) break;
    end
    check(v[7], 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, en, rt, cnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    rd(2'd0, v); check(v, 0, "R10 axis control reset");
    rd(2'd1, v); check(v, 0, "R10 value reset");
    rd(2'd2, v); check(v, 0, "R10 timing control reset");
    check(int'(irq), 0, "R10 irq reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: R1 R2 R3 R4 R5 R7
    for (int n = 0; n < NV; n++) begin
      en = VEC[n][0]; rt = VEC[n][1];
      wr(2'd2, 8'(rt << 1));
      wr(2'd0, 8'(en));
      for (int k = 0; k < 4; k++) len[k] = VEC[n][2+k];
      wr(2'd1, 8'h00);
      wait_ready("R6 ready after vector");
      for (int k = 0; k < 4; k++) begin
        if (en[k]) begin
          expv[k] = len[k] / divisor(rt);
          if (expv[k] > TOP) expv[k] = TOP;
        end
        wr(2'd0, 8'(en | (k << 4)));
        rd(2'd1, v);
        check(v, expv[k], $sformatf("R2/R5 vec%0d axis%0d (R1 R3 R4)", n, k));
      end
    end

    // R10: upper timing control bits read zero
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check(v, 7, "R10 timing control bits 7:3 zero");

    // R9: irq follows enable and ready
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01);
    len = '{4, 0, 0, 0};
    wr(2'd1, 8'h00);
    // R7 R6: ready cleared by the write
    rd(2'd0, v); check(v[7], 0, "R6 ready cleared by value write");
    check(int'(irq), 0, "R9 irq low while measuring");
    wait_ready("R6 ready after irq run");
    check(int'(irq), 1, "R9 irq with enable and ready");
    wr(2'd2, 8'h00);
    check(int'(irq), 0, "R9 irq masked by enable");

    // R6: bit 7 not writable
    wr(2'd0, 8'h81);
    rd(2'd0, v); check(v & 8'h7F, 8'h01, "R6 control low bits after write");
    check(v[7], 1, "R6 bit7 still reflects ready");

    // R8: continuous mode pulses ready repeatedly
    len = '{0, 0, 0, 0};
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h41);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq) cnt++;
    end
    check(int'(cnt >= 5), 1, "R8 repeated ready pulses");
    check(int'(cnt <= 30), 1, "R8 ready pulses not held");
    wr(2'd0, 8'h01);
    wait_ready("R8 ready after leaving continuous mode");
    repeat (5) @(negedge clk);
    rd(2'd0, v); check(v[7], 1, "R8 ready stays set without continuous");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule